// File: doc/BRIEF.md
# Two-Bank Latched Interrupt Controller

This block gathers up to 64 interrupt inputs into two banks of 32 and drives one request line toward a processor or toward an input of a parent controller. Several instances can therefore be chained. Each bank has four word registers: captured events, mask, acknowledge and live level. A rising edge on an enabled input sets its event bit. The bit stays set until software writes a 1 to the matching acknowledge bit. The request line is high while any captured event is also enabled.

Software can read the live input state at any time, and it can poll the mask register to confirm that a mask change has landed. An input that is already held high when it is enabled does not create an event, so the driver must look at the level register itself. A priority encoder returns the highest-numbered pending source with a valid flag. The upper bank wins, because its sources carry the higher numbers.

The register port is single-cycle. A write takes effect at the clock edge where `bus_we` is high. Read data is combinational from `bus_addr`. Inputs are assumed to be synchronous to `clk`.

Top module: `latched_irq_ctrl`

## Requirements
- R1: Within the 64-byte window, sources 0..31 use byte offsets 0x20 (event), 0x24 (mask), 0x28 (acknowledge) and 0x2C (level). Sources 32..63 use 0x10, 0x14, 0x18 and 0x1C in the same roles. Every other offset, and every offset with a nonzero low two bits, reads 0 and ignores writes.
- R2: Source n maps to bank n>>5 at data bit n&31. Data bit 0 is the least significant bit of byte lane 0 (little-endian).
- R3: A rising input edge while the source's mask bit is 1 sets its event bit in the next cycle. A rising edge while the mask bit is 0 leaves the event bit at 0.
- R4: Writing 1 to an acknowledge bit clears that event bit. Bits written as 0 change nothing. The acknowledge offset always reads 0.
- R5: The mask register reads back exactly the last value written to it.
- R6: The level register returns the raw input state, whatever the mask and event state.
- R7: Setting a mask bit while the input is already held high creates no event and does not raise the request.
- R8: `irq_o` is high exactly when some source has both its event bit and its mask bit set. Clearing the mask drops the request but keeps the event bit set.
- R9: When a source is pending, `top_valid` is 1 and `top_id` gives the highest pending source number. Otherwise both outputs are 0.
- R10: After reset, the mask and event registers and `irq_o` are 0.
- R11: If an acknowledge of a bit and a new rising edge on that bit fall in the same cycle, the event bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | 64 | Interrupt inputs, active high |
| bus_addr | input | 6 | Byte offset into the register window |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq_o | output | 1 | Combined interrupt request |
| top_valid | output | 1 | A source is pending |
| top_id | output | 6 | Highest pending source number |

## Verification
An acknowledge write and a fresh rising edge can land on the same event bit in the same clock cycle. The bench provokes this by raising input 12 and writing its acknowledge bit in one cycle. It then expects bit 12 of the event register still set and the request still high. A second acknowledge with no edge must then clear the bit. The bench also checks a mask write that coincides with an input already held high, and expects no event from it.

// File: rtl/latched_irq_ctrl.sv
module latched_irq_ctrl #(
  parameter int          BANK_W  = 32,
  parameter logic [5:0]  LO_BASE = 6'h20,
  parameter logic [5:0]  HI_BASE = 6'h10
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [2*BANK_W-1:0]        src_i,
  input  logic [5:0]                 bus_addr,
  input  logic                       bus_we,
  input  logic [BANK_W-1:0]          bus_wdata,
  output logic [BANK_W-1:0]          bus_rdata,
  output logic                       irq_o,
  output logic                       top_valid,
  output logic [$clog2(2*BANK_W)-1:0] top_id
);
  localparam int NSRC = 2 * BANK_W;
  localparam int ID_W = $clog2(NSRC);

  logic [NSRC-1:0] src_q, ev_q, en_q;
  logic [NSRC-1:0] rise, ack_mask, pending;
  logic            aligned, sel_lo, sel_hi;
  logic [1:0]      reg_sel;

  assign aligned = (bus_addr[1:0] == 2'b00);
  assign sel_lo  = aligned && (bus_addr[5:4] == LO_BASE[5:4]);
  assign sel_hi  = aligned && (bus_addr[5:4] == HI_BASE[5:4]);
  assign reg_sel = bus_addr[3:2];

  assign rise     = src_i & ~src_q;
  assign ack_mask = {(bus_we && sel_hi && reg_sel == 2'd2) ? bus_wdata : '0,
                     (bus_we && sel_lo && reg_sel == 2'd2) ? bus_wdata : '0};
  assign pending  = ev_q & en_q;
  assign irq_o    = |pending;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q <= '0;
      ev_q  <= '0;
      en_q  <= '0;
    end else begin
      src_q <= src_i;
      ev_q  <= (ev_q & ~ack_mask) | (rise & en_q);
      if (bus_we && sel_lo && reg_sel == 2'd1) en_q[BANK_W-1:0]    <= bus_wdata;
      if (bus_we && sel_hi && reg_sel == 2'd1) en_q[NSRC-1:BANK_W] <= bus_wdata;
    end
  end

  function automatic logic [BANK_W-1:0] bank_read(input logic [1:0] r,
      input logic [BANK_W-1:0] ev, input logic [BANK_W-1:0] en,
      input logic [BANK_W-1:0] lv);
    case (r)
      2'd0:    return ev;
      2'd1:    return en;
      2'd3:    return lv;
      default: return '0;
    endcase
  endfunction

  always_comb begin
    bus_rdata = '0;
    if (sel_lo)
      bus_rdata = bank_read(reg_sel, ev_q[BANK_W-1:0], en_q[BANK_W-1:0], src_i[BANK_W-1:0]);
    else if (sel_hi)
      bus_rdata = bank_read(reg_sel, ev_q[NSRC-1:BANK_W], en_q[NSRC-1:BANK_W], src_i[NSRC-1:BANK_W]);
  end

  always_comb begin
    top_valid = 1'b0;
    top_id    = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (pending[i]) begin
        top_valid = 1'b1;
        top_id    = ID_W'(i);
      end
    end
  end

  p_ack_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((ev_q & $past(ack_mask & ~(rise & en_q))) == '0));

  p_held_no_event_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((ev_q & ~$past(ev_q) & $past(src_q)) == '0));

  p_masked_no_event_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((ev_q & ~$past(ev_q) & ~$past(en_q)) == '0));

  p_mask_readback_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && sel_lo && reg_sel == 2'd1) |=> (en_q[BANK_W-1:0] == $past(bus_wdata)));

  p_edge_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((($past(rise & en_q)) & ~ev_q) == '0));

  p_top_is_highest_r9: assert property (@(posedge clk) disable iff (!rst_n)
    top_valid |-> ((pending >> top_id) == NSRC'(1)));

  p_valid_tracks_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    top_valid == irq_o);
endmodule

// File: tb/latched_irq_ctrl_test.sv
module latched_irq_ctrl_test;
  logic        clk = 0, rst_n = 0;
  logic [63:0] src_i = '0;
  logic [5:0]  bus_addr = '0;
  logic        bus_we = 0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o, top_valid;
  logic [5:0]  top_id;
  int          checks = 0, fails = 0;
  bit          done = 0;

  localparam logic [5:0] LEV = 6'h20, LEN = 6'h24, LACK = 6'h28, LLV = 6'h2C;
  localparam logic [5:0] HEV = 6'h10, HEN = 6'h14, HACK = 6'h18, HLV = 6'h1C;

  always #5 clk = ~clk;

  latched_irq_ctrl uut (.clk(clk), .rst_n(rst_n), .src_i(src_i), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o),
    .top_valid(top_valid), .top_id(top_id));

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; #1 d = bus_rdata;
  endtask

  task automatic drive(logic [63:0] v);
    @(negedge clk); src_i = v;
    @(negedge clk);
  endtask

  task automatic clean();
    drive('0);
    wr(LEN, '0); wr(HEN, '0);
    wr(LACK, '1); wr(HACK, '1);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(LEV, d); chk("R10 lo event", d, 0);
    rd(LEN, d); chk("R10 lo mask", d, 0);
    rd(HEV, d); chk("R10 hi event", d, 0);
    rd(HEN, d); chk("R10 hi mask", d, 0);
    chk("R10 irq", irq_o, 0);
    chk("R9 idle valid", {top_valid, top_id}, 0);
  endtask

  task automatic t_level();
    logic [31:0] d;
    drive(64'hA5A5_0F0F_0000_3C3C);
    rd(LLV, d); chk("R6 R2 lo level", d, 32'h0000_3C3C);
    rd(HLV, d); chk("R6 R2 hi level", d, 32'hA5A5_0F0F);
    rd(LEV, d); chk("R3 no event while masked", d, 0);
    chk("R6 irq quiet", irq_o, 0);
    clean();
  endtask

  task automatic t_edge_ack();
    logic [31:0] d;
    wr(LEN, 32'h0000_0008);
    drive(64'h0000_0000_0000_0028);
    rd(LEV, d); chk("R3 edge latched only when enabled", d, 32'h8);
    chk("R8 irq up", irq_o, 1);
    drive('0);
    rd(LEV, d); chk("R3 event persists after input falls", d, 32'h8);
    wr(LACK, 32'hFFFF_FFF7);
    rd(LEV, d); chk("R4 zero ack bits ignored", d, 32'h8);
    rd(LACK, d); chk("R4 ack reads zero", d, 0);
    wr(LACK, 32'h8);
    rd(LEV, d); chk("R4 ack clears", d, 0);
    chk("R8 irq down", irq_o, 0);
    clean();
  endtask

  task automatic t_readback();
    logic [31:0] d;
    wr(HEN, 32'hDEAD_BEEF);
    rd(HEN, d); chk("R5 hi mask readback", d, 32'hDEAD_BEEF);
    wr(LEN, 32'h1234_5678);
    rd(LEN, d); chk("R5 lo mask readback", d, 32'h1234_5678);
    clean();
  endtask

  task automatic t_held();
    logic [31:0] d;
    drive(64'h0000_0400_0000_0400);
    wr(LEN, 32'h400); wr(HEN, 32'h400);
    repeat (2) @(negedge clk);
    rd(LEV, d); chk("R7 held lo no event", d, 0);
    rd(HEV, d); chk("R7 held hi no event", d, 0);
    chk("R7 no request", irq_o, 0);
    clean();
  endtask

  task automatic t_mask_drop();
    logic [31:0] d;
    wr(HEN, 32'h1);
    drive(64'h0000_0001_0000_0000);
    chk("R8 R2 source 32 requests", irq_o, 1);
    wr(HEN, 32'h0);
    chk("R8 masked drops irq", irq_o, 0);
    rd(HEV, d); chk("R8 event kept while masked", d, 32'h1);
    clean();
  endtask

  task automatic t_encoder();
    wr(LEN, 32'h80); wr(HEN, 32'h100);
    drive(64'h0000_0100_0000_0080);
    chk("R9 upper wins", {top_valid, top_id}, {1'b1, 6'd40});
    wr(HACK, 32'h100);
    chk("R9 then lower", {top_valid, top_id}, {1'b1, 6'd7});
    wr(LACK, 32'h80);
    chk("R9 none pending", {top_valid, top_id}, 0);
    clean();
  endtask

  task automatic t_collide();
    logic [31:0] d;
    wr(LEN, 32'h1000);
    @(negedge clk); src_i[12] = 1; bus_addr = LACK; bus_wdata = 32'h1000; bus_we = 1;
    @(negedge clk); bus_we = 0;
    rd(LEV, d); chk("R11 edge beats ack", d, 32'h1000);
    chk("R11 irq stays", irq_o, 1);
    wr(LACK, 32'h1000);
    rd(LEV, d); chk("R11 later ack clears", d, 0);
    clean();
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    wr(6'h00, '1); wr(6'h30, '1); wr(6'h25, '1); wr(6'h04, '1);
    rd(LEN, d); chk("R1 lo mask untouched", d, 0);
    rd(HEN, d); chk("R1 hi mask untouched", d, 0);
    drive(64'hFFFF_FFFF_FFFF_FFFF);
    rd(6'h30, d); chk("R1 hole reads zero", d, 0);
    rd(6'h2D, d); chk("R1 misaligned reads zero", d, 0);
    chk("R1 no events from holes", irq_o, 0);
    clean();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset(); t_level(); t_edge_ack(); t_readback(); t_held();
    t_mask_drop(); t_encoder(); t_collide(); t_unmapped();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule